// File: doc/BRIEF.md
# Carry-Save Accumulating Multiply-Accumulate Core

This block repeatedly multiplies two W-bit operands and adds the product into a 2W-bit running total. The total is never resolved inside the accumulation loop. It is held in redundant form: a sum vector, a carry vector, a small field of already-resolved low bits, and a single pending carry bit. Each accepted operand pair produces radix-4 Booth partial products. These are compressed in a carry-save tree together with the stored redundant state. A two-bit lookahead stage then settles the low bits of the tree output, so that only the upper part of the word ever needs a full carry-propagate adder.

That full adder runs only when the total is read. A read request returns the resolved value one cycle later, with a one-cycle valid pulse. A per-operation mode input selects whether the operands are taken as two's complement or as unsigned numbers. A clear input empties the total. When clear arrives together with an operand pair, the total is loaded with that product alone.

Top module: `mac_cs`

## Requirements
- R1: After reset the total is zero and `res_valid` is low; a read issued right after reset returns 0.
- R2: With `op_unsigned` = 0, an accepted pair (`in_valid` = 1) adds the two's complement product of `op_a` and `op_b` to the total.
- R3: With `op_unsigned` = 1, an accepted pair adds the unsigned product of `op_a` and `op_b` to the total. The mode may change from one operation to the next.
- R4: The total wraps modulo 2^(2W) with no saturation and no overflow indication.
- R5: `clr` = 1 with `in_valid` = 0 makes the total zero at that clock edge.
- R6: `clr` = 1 with `in_valid` = 1 replaces the total with the product of that pair alone.
- R7: In a cycle with `in_valid` = 0 and `clr` = 0, the total is unchanged.
- R8: `rd_req` = 1 at an edge makes `res_valid` high for exactly the following cycle. In that cycle `res` holds the total as it stood before that edge, so an operation or clear accepted at the same edge is not included.
- R9: A continuous run of read requests gives one valid cycle per request, and each one reports the total as it stood at the moment of its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Empty the total (loads the product if `in_valid` is also high) |
| in_valid | input | 1 | Operand pair present this cycle |
| op_unsigned | input | 1 | 1: unsigned operands, 0: two's complement |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier, Booth recoded |
| rd_req | input | 1 | Request the resolved total |
| res_valid | output | 1 | One-cycle pulse, one cycle after `rd_req` |
| res | output | 2W | Resolved total |

## Verification
The bench builds the core with its defaults: W = 16, which gives a 32-bit total, nine Booth groups and a 13-row compression tree, and a two-bit pre-resolved low field. These sizes bring several corner values within reach. They include the most negative operand, all-ones operands read in both modes, and the top Booth group, which is present only because of the unsigned extension. They also make wrap-around past 2^32 reachable after a few unsigned all-ones products. Because the low field is two bits wide, the pending carry bit is exercised on almost every accumulation.

// File: rtl/mac_cs.sv
module mac_cs #(
  parameter int W   = 16,
  parameter int LOW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             op_unsigned,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             rd_req,
  output logic             res_valid,
  output logic [2*W-1:0]   res
);

  localparam int ACCW = 2 * W;
  localparam int HIW  = ACCW - LOW;
  localparam int EW   = ((W + 2) / 2) * 2;
  localparam int NG   = EW / 2;
  localparam int NR   = NG + 4;

  function automatic int rows_at(int lv);
    int n = NR;
    for (int i = 0; i < lv; i++) n = (n / 3) * 2 + n % 3;
    return n;
  endfunction

  function automatic int level_count();
    int n = NR;
    int l = 0;
    while (n > 2) begin
      n = (n / 3) * 2 + n % 3;
      l++;
    end
    return l;
  endfunction

  localparam int NLV = level_count();

  logic [HIW-1:0]  s_hi, c_hi;
  logic [LOW-1:0]  lo_q;
  logic            k_q;

  logic            a_sx, b_sx;
  logic [ACCW-1:0] ax;
  logic [EW:0]     bext;
  logic [ACCW-1:0] fb;
  logic [ACCW-1:0] neg_row;
  logic [ACCW-1:0] lvl [NLV+1][NR];

  assign a_sx = ~op_unsigned & op_a[W-1];
  assign b_sx = ~op_unsigned & op_b[W-1];
  assign ax   = {{(ACCW-W){a_sx}}, op_a};
  assign bext = {{(EW-W){b_sx}}, op_b, 1'b0};
  assign fb   = {ACCW{~clr}};

  // Booth radix-4 partial products; negation completed by neg_row bits
  logic [NG-1:0] neg_bits;
  for (genvar g = 0; g < NG; g++) begin : g_pp
    localparam int SH = 2 * g;
    logic [2:0]      trip;
    logic            one, two, neg;
    logic [ACCW-1:0] mag;
    assign trip = bext[SH+2:SH];
    assign one  = trip[1] ^ trip[0];
    assign two  = (trip == 3'b011) | (trip == 3'b100);
    assign neg  = trip[2] & ~(trip[1] & trip[0]);
    assign mag  = one ? ax : (two ? {ax[ACCW-2:0], 1'b0} : '0);
    assign lvl[0][g] = (neg ? ~mag : mag) << SH;
    assign neg_bits[g] = neg;
  end

  always_comb begin
    neg_row = '0;
    for (int g = 0; g < NG; g++) neg_row[2*g] = neg_bits[g];
  end

  assign lvl[0][NG]   = neg_row;
  assign lvl[0][NG+1] = {s_hi, lo_q} & fb;
  assign lvl[0][NG+2] = {c_hi, {LOW{1'b0}}} & fb;
  assign lvl[0][NG+3] = (ACCW'(k_q) << LOW) & fb;

  // 3:2 compression tree, level by level
  for (genvar l = 0; l < NLV; l++) begin : g_lvl
    localparam int NIN  = rows_at(l);
    localparam int NT   = NIN / 3;
    localparam int NOUT = rows_at(l + 1);
    for (genvar t = 0; t < NT; t++) begin : g_csa
      logic [ACCW-1:0] x, y, z, maj;
      assign x   = lvl[l][3*t];
      assign y   = lvl[l][3*t+1];
      assign z   = lvl[l][3*t+2];
      assign maj = (x & y) | (x & z) | (y & z);
      assign lvl[l+1][2*t]   = x ^ y ^ z;
      assign lvl[l+1][2*t+1] = {maj[ACCW-2:0], 1'b0};
    end
    for (genvar r = 0; r < NIN % 3; r++) begin : g_pass
      assign lvl[l+1][2*NT+r] = lvl[l][3*NT+r];
    end
    for (genvar r = NOUT; r < NR; r++) begin : g_zero
      assign lvl[l+1][r] = '0;
    end
  end

  for (genvar r = rows_at(0); r < NR; r++) begin : g_zero0
    assign lvl[0][r] = '0;
  end

  logic [ACCW-1:0] s2, c2;
  assign s2 = lvl[NLV][0];
  assign c2 = lvl[NLV][1];

  // early resolution of the low field
  logic [LOW-1:0] gl, pl, lo_n;
  logic [LOW:0]   cy;
  always_comb begin
    gl = s2[LOW-1:0] & c2[LOW-1:0];
    pl = s2[LOW-1:0] ^ c2[LOW-1:0];
    cy = '0;
    for (int i = 0; i < LOW; i++) cy[i+1] = gl[i] | (pl[i] & cy[i]);
    lo_n = pl ^ cy[LOW-1:0];
  end

  always_comb begin
    assert_low_resolve_R2: assert ({cy[LOW], lo_n} == ({1'b0, s2[LOW-1:0]} + {1'b0, c2[LOW-1:0]}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hi <= '0;
      c_hi <= '0;
      lo_q <= '0;
      k_q  <= 1'b0;
    end else if (in_valid) begin
      s_hi <= s2[ACCW-1:LOW];
      c_hi <= c2[ACCW-1:LOW];
      lo_q <= lo_n;
      k_q  <= cy[LOW];
    end else if (clr) begin
      s_hi <= '0;
      c_hi <= '0;
      lo_q <= '0;
      k_q  <= 1'b0;
    end
  end

  // final adder, used only on read
  logic [ACCW-1:0] acc_val;
  assign acc_val = {s_hi + c_hi + HIW'(k_q), lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= rd_req;
      if (rd_req) res <= acc_val;
    end
  end

  // reference product for checking the accumulation loop
  logic [ACCW-1:0] prod_ref;
  assign prod_ref = op_unsigned ? ({{W{1'b0}}, op_a} * {{W{1'b0}}, op_b})
                                : ACCW'($signed(op_a) * $signed(op_b));

  assert_accumulate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> acc_val == $past(acc_val) + $past(prod_ref));

  assert_load_product_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clr) |=> acc_val == $past(prod_ref));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> acc_val == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_valid) |=> $stable(acc_val));

  assert_read_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> res_valid && res == $past(acc_val));

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !res_valid);

endmodule

// File: tb/mac_cs_tb.sv
module mac_cs_tb;
  localparam int W = 16;
  localparam int ACCW = 2 * W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            clr = 1'b0, in_valid = 1'b0, op_unsigned = 1'b0, rd_req = 1'b0;
  logic [W-1:0]    op_a = '0, op_b = '0;
  logic            res_valid;
  logic [ACCW-1:0] res;

  int n_chk = 0, n_bad = 0;
  logic [ACCW-1:0] model = '0;

  always #10 clk = ~clk;

  mac_cs #(.W(W), .LOW(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .op_unsigned(op_unsigned), .op_a(op_a), .op_b(op_b),
    .rd_req(rd_req), .res_valid(res_valid), .res(res)
  );

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         uns;
    logic         cl;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'h0003, 16'h0004, 1'b0, 1'b0},
    '{16'hFFFF, 16'h0005, 1'b0, 1'b0},
    '{16'h7FFF, 16'h7FFF, 1'b0, 1'b0},
    '{16'h8000, 16'h8000, 1'b0, 1'b0},
    '{16'h8000, 16'h7FFF, 1'b0, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    '{16'h2AC9, 16'h006A, 1'b1, 1'b0},
    '{16'hAAAA, 16'h5555, 1'b0, 1'b1},
    '{16'h8000, 16'h8000, 1'b1, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0}
  };

  function automatic logic [ACCW-1:0] prod(logic [W-1:0] a, logic [W-1:0] b, logic uns);
    logic signed [ACCW-1:0] sa, sb;
    if (uns) return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic check(string req, logic [ACCW-1:0] act, logic [ACCW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [W-1:0] a, logic [W-1:0] b, logic uns, logic cl);
    op_a = a; op_b = b; op_unsigned = uns; clr = cl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic read_chk(string req, logic [ACCW-1:0] exp);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check({req, " valid"}, {31'b0, res_valid}, 1);
    check(req, res, exp);
    @(negedge clk);
    check({req, " pulse end"}, {31'b0, res_valid}, 0);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 res_valid after reset", {31'b0, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk("R1 reset total", '0);

    // table walk: R2 signed, R3 unsigned, R4 wrap, R6 clear+load
    foreach (VECS[i]) begin
      if (VECS[i].cl) model = prod(VECS[i].a, VECS[i].b, VECS[i].uns);
      else model = model + prod(VECS[i].a, VECS[i].b, VECS[i].uns);
      op(VECS[i].a, VECS[i].b, VECS[i].uns, VECS[i].cl);
      read_chk(VECS[i].cl ? "R6 clear with load" :
               (VECS[i].uns ? "R3 unsigned accumulate" : "R2 signed accumulate"), model);
    end

    // R4: unsigned all-ones five times from zero wraps past 2^32
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    read_chk("R5 clear alone", '0);
    model = '0;
    for (int k = 0; k < 5; k++) begin
      op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
      model = model + 32'hFFFE_0001;
    end
    read_chk("R4 wrap modulo 2^32", 32'hFFF6_0005);
    check("R4 model agrees", model, 32'hFFF6_0005);

    // R7: idle cycles keep the total
    repeat (5) @(negedge clk);
    read_chk("R7 idle hold", model);

    // R8: read at the same edge as an operation reports the earlier total
    op_a = 16'h0010; op_b = 16'hFFF0; op_unsigned = 1'b0; in_valid = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b0;
    check("R8 same-edge read valid", {31'b0, res_valid}, 1);
    check("R8 same-edge read excludes op", res, model);
    model = model + 32'hFFFF_FF00;
    @(negedge clk);
    read_chk("R8 following read", model);

    // R8: read at the same edge as a clear reports the total before clearing
    clr = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    clr = 1'b0; rd_req = 1'b0;
    check("R8 read with clear", res, model);
    model = '0;
    @(negedge clk);

    // R9: back-to-back reads across an operation
    op(16'h0002, 16'h0003, 1'b0, 1'b0);
    rd_req = 1'b1;
    op_a = 16'h0004; op_b = 16'h0005; op_unsigned = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 first of run valid", {31'b0, res_valid}, 1);
    check("R9 first of run", res, 32'd6);
    @(negedge clk);
    rd_req = 1'b0;
    check("R9 second of run valid", {31'b0, res_valid}, 1);
    check("R9 second of run", res, 32'd26);
    @(negedge clk);
    check("R9 run end", {31'b0, res_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule